// File: doc/BRIEF.md
# Global Search Supervisor Sequencer

This block decides when a photovoltaic power tracker stops its local hill-climbing and looks over the whole operating range for the highest power peak. A free-running counter is made of a fast dither section followed by a long timeout section. Each time the counter's top bit rises, a global search begins. The search walks through four control phases that never overlap:

- the peak stores are cleared while the servo is held;
- the first sweep runs while peak store 1 captures;
- the servo is held a second time;
- the second sweep runs while peak store 2 captures.

Each phase ends when a chosen counter bit rises for the first time in the search.

The second sweep ends early when an external comparator reports that the running peak has reached the stored first peak. That report arrives asynchronously and is synchronised by two flip-flops. The global-run output then returns control to local dithering. If the comparator never trips, the run ends when the counter's top bit falls. The search therefore takes a small and bounded share of every timeout period.

All control outputs are active low. The counter widths and the three phase-boundary bit positions are parameters, so a short timeout can be built for simulation.

Top module: `search_supervisor`

## Requirements
- R1: During and after reset all five outputs are high (inactive), and they stay high until the counter's top bit first rises, 2^(PRE_W+TMO_W-1) counts after reset.
- R2: A search begins every 2^(PRE_W+TMO_W) counts, when the top counter bit rises. At that count, offset 0, `global_run_no` and `store_clr_no` go low.
- R3: `store_clr_no` is low for search offsets 0 to 2^CLR_BIT-1.
- R4: `capture1_no` is low for search offsets 2^CLR_BIT to 2^CAP1_BIT-1.
- R5: The second servo phase covers search offsets 2^CAP1_BIT to 2^SRV_BIT-1. `servo_no` is low exactly when the clear phase or the second servo phase is active.
- R6: `capture2_no` goes low at offset 2^SRV_BIT and stays low until the run ends.
- R7: At most one of the clear phase, capture 1, the second servo phase and capture 2 is active in any cycle.
- R8: If `trip_i` is sampled high at offset t and held, the run ends at offset max(t+3, 2^SRV_BIT+1), capped at 2^(PRE_W+TMO_W-1). At that offset `capture2_no` and `global_run_no` return high.
- R9: A trip that arrives before capture 2 does not shorten the clear, capture 1 or second servo phases. It ends the run at offset 2^SRV_BIT+1.
- R10: With no trip, capture 2 and the global run end at offset 2^(PRE_W+TMO_W-1), when the top counter bit falls.
- R11: The run flag is re-armed at the start of every search, even when `trip_i` has stayed high since before the search. `global_run_no` is low from offset 0 until the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, same as the converter's sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trip_i | input | 1 | Asynchronous comparator flag: second peak has reached first peak |
| store_clr_no | output | 1 | Active-low clear of both peak stores |
| capture1_no | output | 1 | Active-low enable of peak store 1 (first sweep) |
| servo_no | output | 1 | Active-low servo hold (clear phase or second servo phase) |
| capture2_no | output | 1 | Active-low enable of peak store 2 (second sweep) |
| global_run_no | output | 1 | Active-low global search in progress |

## Verification
The bench builds the block with PRE_W=4, TMO_W=3, CLR_BIT=1, CAP1_BIT=2 and SRV_BIT=3. This gives a 128-cycle timeout and a 64-cycle window for each search, so every cycle of 65 consecutive periods can be compared with arithmetic expectations. The trip flag is raised at every offset of the search window in turn, once during the idle half, and not at all. This covers trips ignored in early phases, trips that end capture 2 at each possible offset, trips so late that the top-bit fall wins, and re-arming while the flag is still high.

// File: rtl/gss_pkg.sv
package gss_pkg;
  localparam int unsigned NSTEP = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_CAP1,
    PH_SERVO2,
    PH_CAP2
  } phase_e;
endpackage

// File: rtl/gss_sync2.sv
module gss_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gss_timebase.sv
module gss_timebase
  import gss_pkg::*;
#(
  parameter int unsigned PRE_W    = 10,
  parameter int unsigned TMO_W    = 14,
  parameter int unsigned CLR_BIT  = 9,
  parameter int unsigned CAP1_BIT = 10,
  parameter int unsigned SRV_BIT  = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             glob_o,
  output logic             glob_rise_o,
  output logic             glob_fall_o,
  output logic [NSTEP-1:0] step_rise_o
);
  localparam int unsigned CNT_W = PRE_W + TMO_W;
  localparam int unsigned MSB   = CNT_W - 1;
  localparam int unsigned STEP_BIT [NSTEP] = '{CLR_BIT, CAP1_BIT, SRV_BIT};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign glob_o      = cnt_q[MSB];
  assign glob_rise_o = cnt_d[MSB] & ~cnt_q[MSB];
  assign glob_fall_o = ~cnt_d[MSB] & cnt_q[MSB];

  for (genvar gi = 0; gi < NSTEP; gi++) begin : g_step
    assign step_rise_o[gi] = cnt_d[STEP_BIT[gi]] & ~cnt_q[STEP_BIT[gi]];
  end

  AST_SEARCH_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_rise_o |=> (cnt_q[MSB-1:0] == '0)) else $error("search start not aligned"); // R2
endmodule

// File: rtl/gss_phase_chain.sv
module gss_phase_chain
  import gss_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glob_rise_i,
  input  logic             glob_fall_i,
  input  logic [NSTEP-1:0] step_rise_i,
  input  logic             trip_s_i,
  output phase_e           phase_o,
  output logic             armed_o
);
  phase_e phase_q, phase_d;
  logic   armed_q, armed_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (glob_rise_i)    phase_d = PH_CLEAR;
      PH_CLEAR:  if (step_rise_i[0]) phase_d = PH_CAP1;
      PH_CAP1:   if (step_rise_i[1]) phase_d = PH_SERVO2;
      PH_SERVO2: if (step_rise_i[2]) phase_d = PH_CAP2;
      PH_CAP2:   if (trip_s_i)       phase_d = PH_IDLE;
      default:                       phase_d = PH_IDLE;
    endcase
    if (glob_fall_i) phase_d = PH_IDLE;
  end

  always_comb begin
    armed_d = armed_q;
    if (glob_rise_i)                          armed_d = 1'b1;
    else if (phase_q == PH_CAP2 && trip_s_i)  armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      armed_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      armed_q <= armed_d;
    end
  end

  assign phase_o = phase_q;
  assign armed_o = armed_q;

  AST_TRIP_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CAP2 && trip_s_i) |=> (phase_q == PH_IDLE && !armed_q)) else $error("trip did not end run"); // R8
  AST_EARLY_TRIP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q inside {PH_CLEAR, PH_CAP1, PH_SERVO2} && trip_s_i && !glob_fall_i)
      |=> (phase_q != PH_IDLE)) else $error("early trip cut a phase"); // R9
  AST_REARM_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_rise_i |=> (armed_q && phase_q == PH_CLEAR)) else $error("run not re-armed"); // R11
endmodule

// File: rtl/search_supervisor.sv
module search_supervisor
  import gss_pkg::*;
#(
  parameter int unsigned PRE_W    = 10,
  parameter int unsigned TMO_W    = 14,
  parameter int unsigned CLR_BIT  = 9,
  parameter int unsigned CAP1_BIT = 10,
  parameter int unsigned SRV_BIT  = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  output logic store_clr_no,
  output logic capture1_no,
  output logic servo_no,
  output logic capture2_no,
  output logic global_run_no
);
  logic             rst_n_sync;
  logic             glob, glob_rise, glob_fall, trip_s, armed;
  logic [NSTEP-1:0] step_rise;
  phase_e           phase;
  logic             clr_act, cap1_act, srv2_act, cap2_act;

  gss_sync2 i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (1'b1),
    .q_o    (rst_n_sync)
  );

  gss_sync2 i_trip_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .d_i    (trip_i),
    .q_o    (trip_s)
  );

  gss_timebase #(
    .PRE_W    (PRE_W),
    .TMO_W    (TMO_W),
    .CLR_BIT  (CLR_BIT),
    .CAP1_BIT (CAP1_BIT),
    .SRV_BIT  (SRV_BIT)
  ) i_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .glob_o      (glob),
    .glob_rise_o (glob_rise),
    .glob_fall_o (glob_fall),
    .step_rise_o (step_rise)
  );

  gss_phase_chain i_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .glob_rise_i (glob_rise),
    .glob_fall_i (glob_fall),
    .step_rise_i (step_rise),
    .trip_s_i    (trip_s),
    .phase_o     (phase),
    .armed_o     (armed)
  );

  assign clr_act  = (phase == PH_CLEAR);
  assign cap1_act = (phase == PH_CAP1);
  assign srv2_act = (phase == PH_SERVO2);
  assign cap2_act = (phase == PH_CAP2);

  assign store_clr_no  = ~clr_act;
  assign capture1_no   = ~cap1_act;
  assign capture2_no   = ~cap2_act;
  assign servo_no      = ~clr_act & ~srv2_act;
  assign global_run_no = ~(glob & armed);

  AST_PHASES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    $onehot0({~store_clr_no, ~capture1_no, ~capture2_no, (servo_no == store_clr_no) ? 1'b0 : 1'b1}))
    else $error("phases overlap"); // R7
  AST_CAP1_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    $fell(capture1_no) |-> !$past(store_clr_no)) else $error("capture 1 out of order"); // R4
  AST_CAP2_AFTER_SERVO: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    $fell(capture2_no) |-> (!$past(servo_no) && $past(store_clr_no))) else $error("capture 2 out of order"); // R6
  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    glob_rise |=> (!store_clr_no && !global_run_no)) else $error("search did not start"); // R2
  AST_PHASE_NEEDS_GLOB: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !glob |-> (store_clr_no && capture1_no && capture2_no && servo_no && global_run_no))
    else $error("activity outside search window"); // R1
endmodule

// File: tb/test_search_supervisor.sv
module test_search_supervisor;
  localparam int unsigned PRE_W = 4, TMO_W = 3;
  localparam int unsigned CLR_BIT = 1, CAP1_BIT = 2, SRV_BIT = 3;
  localparam int PERIOD = 1 << (PRE_W + TMO_W);
  localparam int HALF   = PERIOD / 2;
  localparam int O_CLR  = 1 << CLR_BIT;
  localparam int O_CAP1 = 1 << CAP1_BIT;
  localparam int O_SRV  = 1 << SRV_BIT;

  logic clk = 1'b0, rst_n, trip;
  logic clr_n, cap1_n, servo_n, cap2_n, run_n;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  search_supervisor #(
    .PRE_W(PRE_W), .TMO_W(TMO_W),
    .CLR_BIT(CLR_BIT), .CAP1_BIT(CAP1_BIT), .SRV_BIT(SRV_BIT)
  ) i_search_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .trip_i(trip),
    .store_clr_no(clr_n), .capture1_no(cap1_n), .servo_no(servo_n),
    .capture2_no(cap2_n), .global_run_no(run_n)
  );

  task automatic chk(input logic act, input logic exp, input string what, input string tag, input int c);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cnt=%0d: got %0b expected %0b", tag, what, c, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int tc, ox, o;
    bit g;
    string tag_end;
    rst_n = 1'b0; trip = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(clr_n, 1'b1, "store_clr_no in reset", "R1", -1);
    chk(cap1_n, 1'b1, "capture1_no in reset", "R1", -1);
    chk(servo_n, 1'b1, "servo_no in reset", "R1", -1);
    chk(cap2_n, 1'b1, "capture2_no in reset", "R1", -1);
    chk(run_n, 1'b1, "global_run_no in reset", "R1", -1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int p = 0; p < 65; p++) begin
      tc = (p == 0) ? -1 : (p == 1) ? 32 : HALF + p - 2;
      if (tc < 0)          begin ox = HALF;      tag_end = "R10"; end
      else if (tc < HALF)  begin ox = O_SRV + 1; tag_end = "R11"; end
      else begin
        ox = tc - HALF + 3;
        if (ox < O_SRV + 1) ox = O_SRV + 1;
        if (ox > HALF) ox = HALF;
        tag_end = (tc - HALF < O_SRV) ? "R9" : "R8";
      end
      for (int c = 0; c < PERIOD; c++) begin
        g = (c >= HALF);
        o = c - HALF;
        if (!g) begin
          chk(clr_n, 1'b1, "store_clr_no idle", "R1", c);
          chk(cap1_n, 1'b1, "capture1_no idle", "R1", c);
          chk(servo_n, 1'b1, "servo_no idle", "R1", c);
          chk(cap2_n, 1'b1, "capture2_no idle", "R1", c);
          chk(run_n, 1'b1, "global_run_no idle", "R1", c);
        end else begin
          chk(clr_n, !(o < O_CLR), "store_clr_no", (o == 0) ? "R2" : "R3", c);
          chk(cap1_n, !(o >= O_CLR && o < O_CAP1), "capture1_no", "R4", c);
          chk(servo_n, !(o < O_CLR || (o >= O_CAP1 && o < O_SRV)), "servo_no", "R5", c);
          chk(cap2_n, !(o >= O_SRV && o < ox), "capture2_no",
              (o == O_SRV) ? "R6" : tag_end, c);
          chk(run_n, !(o < ox), "global_run_no", (o == 0) ? "R2" : tag_end, c);
        end
        // R7: at most one phase active
        chk(((!clr_n) + (!cap1_n) + (!cap2_n) + ((!servo_n) && clr_n)) <= 1, 1'b1,
            "phase exclusivity", "R7", c);
        if (c == 0) trip = 1'b0;
        if (c == tc) trip = 1'b1;
        @(negedge clk);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule